// File: doc/BRIEF.md
# Dual-Mode Compare Waveform DAC Generator

This block turns an 8-bit digital level into a single-wire waveform for a low-cost digital-to-analog path. An external RC filter, not part of the block, smooths the waveform. A free-running up-counter sets a fixed repetition period of 256 enabled timer ticks. A compare value sets how many ticks of each period drive the output high. In pulse-width mode those high ticks form one contiguous run at the start of the period. In pulse-density mode they are scattered as isolated one-tick pulses spread across the period, which leaves less ripple after the filter.

Software-side logic pushes new compare values over a small valid/ready write channel. Each accepted value waits in a holding register and goes live only at the counter wrap, so no period ever mixes two levels. The mode select is also sampled only at the wrap. Each wrap can produce a one-clock interrupt pulse unless a mask input blocks it. The write channel never applies back-pressure: `cmp_wr_ready` stays high, and a write is accepted in every cycle where `cmp_wr_valid` is high. If several writes land in one period, the last one overrides the others.

Top module: `pwm_pdm_gen`

## Requirements
- R1: While `rst_n` is low and after its release, the counter reads 0, the live compare value is 0, the live mode is pulse-width, `wave_o` is low and `ovf_irq_o` is low.
- R2: The counter advances by one on each clock edge where `tick_en` is high, holds otherwise, and wraps from 255 to 0, giving a period of 256 enabled ticks.
- R3: In pulse-width mode (live mode bit 0), `wave_o` is high exactly while the counter is below the live compare value.
- R4: In pulse-density mode (live mode bit 1), `wave_o` is high exactly while the bit-reversed counter is below the live compare value. This gives compare-value isolated one-tick pulses per period, and no two are adjacent when the value is at most 128.
- R5: `cmp_wr_ready` is always high. A write (`cmp_wr_valid` high at a clock edge) updates only the holding register, and the current period continues with the old live value.
- R6: At the wrap edge the live compare value loads the holding register. A write at the wrap edge itself goes straight into the new period, and the last write in a period wins.
- R7: `mode_pdm` (0 = pulse-width, 1 = pulse-density) is sampled only at the wrap edge, so a change mid-period leaves the rest of that period in the old mode.
- R8: `ovf_irq_o` is a one-clock pulse in the cycle after each wrap edge, while the counter reads 0. It appears only if `irq_mask` was low at that edge (`irq_mask` = 1 suppresses it).
- R9: A live compare value of 0 keeps `wave_o` low in both modes. A value of 255 in pulse-width mode gives 255 high ticks, with the output low only at count 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable; counter advances when high |
| mode_pdm | input | 1 | Mode request, 0 pulse-width, 1 pulse-density |
| cmp_wr_valid | input | 1 | Compare write valid |
| cmp_wr_ready | output | 1 | Compare write ready, tied high |
| cmp_wr_data | input | 8 | Compare write value |
| irq_mask | input | 1 | 1 suppresses the wrap interrupt |
| wave_o | output | 1 | Modulated output |
| ovf_irq_o | output | 1 | One-clock wrap interrupt pulse |

## Verification
`wave_o` is decoded combinationally from registered state. It therefore follows the counter, live compare value and live mode in the same cycle that those registers change, which is one edge after the tick that moved them. A compare write or mode change can show up no earlier than the first cycle after the next wrap edge. The interrupt appears exactly one edge after the wrap edge. The bench drives inputs and samples outputs on falling edges, and advances its own requirement-level model on rising edges. Every sample therefore compares against the model state produced by the same edge that updated the design. Period-level counts start from the first cycle where the model counter reads 0.

// File: rtl/pwm_pdm_pkg.sv
package pwm_pdm_pkg;
  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PDM = 1'b1
  } wave_mode_e;
endpackage

// File: rtl/pwm_free_counter.sv
module pwm_free_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == CNT_MAX);

  // R2: wrap lands on zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));

  // R2: no tick, no motion
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_pdm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             wrap_i,
  input  logic             mode_req_i,
  output logic [WIDTH-1:0] act_cmp_o,
  output wave_mode_e       act_mode_o
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] act_q;
  wave_mode_e       mode_q;
  logic [WIDTH-1:0] load_val;

  // A write arriving on the wrap edge is forwarded into the new period.
  assign load_val = wr_fire_i ? wr_data_i : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr_fire_i) begin
      hold_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      mode_q <= MODE_PWM;
    end else if (wrap_i) begin
      act_q  <= load_val;
      mode_q <= mode_req_i ? MODE_PDM : MODE_PWM;
    end
  end

  assign act_cmp_o  = act_q;
  assign act_mode_o = mode_q;

  // R5: live compare value only moves at a wrap
  p_act_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(act_q));

  // R7: live mode only moves at a wrap
  p_act_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(mode_q));

  // R6: write on the wrap edge becomes live immediately
  p_wrap_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && wr_fire_i) |=> (act_q == $past(wr_data_i)));
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_pdm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] cmp_i,
  input  wave_mode_e       mode_i,
  output logic             wave_o
);
  logic [WIDTH-1:0] cnt_rev;
  logic             pwm_hi;
  logic             pdm_hi;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_rev
    assign cnt_rev[gi] = cnt_i[WIDTH-1-gi];
  end

  assign pwm_hi = (cnt_i < cmp_i);
  assign pdm_hi = (cnt_rev < cmp_i);

  always_comb begin
    unique case (mode_i)
      MODE_PDM: wave_o = pdm_hi;
      default:  wave_o = pwm_hi;
    endcase
  end
endmodule

// File: rtl/pwm_pdm_gen.sv
module pwm_pdm_gen
  import pwm_pdm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mode_pdm,
  input  logic             cmp_wr_valid,
  output logic             cmp_wr_ready,
  input  logic [WIDTH-1:0] cmp_wr_data,
  input  logic             irq_mask,
  output logic             wave_o,
  output logic             ovf_irq_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] cnt;
  logic             wrap;
  logic             wr_fire;
  logic [WIDTH-1:0] act_cmp;
  wave_mode_e       act_mode;
  logic             irq_q;

  assign cmp_wr_ready = 1'b1;
  assign wr_fire      = cmp_wr_valid && cmp_wr_ready;

  pwm_free_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_en),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_shadow_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire_i  (wr_fire),
    .wr_data_i  (cmp_wr_data),
    .wrap_i     (wrap),
    .mode_req_i (mode_pdm),
    .act_cmp_o  (act_cmp),
    .act_mode_o (act_mode)
  );

  pwm_wave_gen #(.WIDTH(WIDTH)) u_wave (
    .cnt_i  (cnt),
    .cmp_i  (act_cmp),
    .mode_i (act_mode),
    .wave_o (wave_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= wrap && !irq_mask;
    end
  end

  assign ovf_irq_o = irq_q;

  // R8: interrupt is a single-cycle pulse
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |=> !ovf_irq_o);

  // R8: interrupt only while the counter reads zero
  p_irq_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |-> (cnt == '0));

  // R8: masked wrap gives no pulse
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && irq_mask) |=> !ovf_irq_o);

  // R9: zero compare keeps the output low
  p_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cmp == '0) |-> !wave_o);

  // R9: pulse-width output is always low at the last count
  p_last_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_PWM && cnt == CNT_MAX) |-> !wave_o);

  // R1: output low in the first cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> (!wave_o && !ovf_irq_o));
endmodule

// File: tb/pwm_pdm_gen_tb.sv
module pwm_pdm_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       mode_pdm = 1'b0;
  logic       cmp_wr_valid = 1'b0;
  logic       cmp_wr_ready;
  logic [7:0] cmp_wr_data = 8'd0;
  logic       irq_mask = 1'b0;
  logic       wave_o;
  logic       ovf_irq_o;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_pdm_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_pdm(mode_pdm),
    .cmp_wr_valid(cmp_wr_valid), .cmp_wr_ready(cmp_wr_ready),
    .cmp_wr_data(cmp_wr_data), .irq_mask(irq_mask),
    .wave_o(wave_o), .ovf_irq_o(ovf_irq_o)
  );

  // requirement-level model, advanced on rising edges
  logic [7:0] m_cnt, m_hold, m_act;
  logic       m_mode, m_irq;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_hold <= 0; m_act <= 0; m_mode <= 0; m_irq <= 0;
    end else begin
      if (cmp_wr_valid) m_hold <= cmp_wr_data;
      m_irq <= tick_en && (m_cnt == 8'd255) && !irq_mask;
      if (tick_en) begin
        if (m_cnt == 8'd255) begin
          m_act  <= cmp_wr_valid ? cmp_wr_data : m_hold;
          m_mode <= mode_pdm;
        end
        m_cnt <= m_cnt + 8'd1;
      end
    end
  end

  function automatic logic exp_wave();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m_cnt[7-i];
    return m_mode ? (r < m_act) : (m_cnt < m_act);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      check(m_mode ? "R4" : "R3", wave_o, exp_wave());
      check("R8", ovf_irq_o, m_irq);
    end
  end

  task automatic write_cmp(input logic [7:0] v);
    cmp_wr_valid = 1'b1; cmp_wr_data = v;
    @(negedge clk);
    cmp_wr_valid = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic wait_wrap();
    wait_cnt(8'd255);
    @(negedge clk);
  endtask

  task automatic count_period(output int highs, output int pairs);
    logic prev = 1'b0;
    highs = 0; pairs = 0;
    for (int i = 0; i < 256; i++) begin
      if (wave_o) highs++;
      if (wave_o && prev) pairs++;
      prev = wave_o;
      @(negedge clk);
    end
  endtask

  // {mode, compare, expected high ticks}
  localparam logic [16:0] VECS [8] = '{
    {1'b0, 8'd0,   8'd0},
    {1'b0, 8'd1,   8'd1},
    {1'b0, 8'd128, 8'd128},
    {1'b0, 8'd255, 8'd255},
    {1'b1, 8'd0,   8'd0},
    {1'b1, 8'd1,   8'd1},
    {1'b1, 8'd128, 8'd128},
    {1'b1, 8'd200, 8'd200}
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int h, p, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", wave_o, 0);
    check("R1", ovf_irq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", wave_o, 0);
    check("R1", ovf_irq_o, 0);
    check("R5", cmp_wr_ready, 1);
    mon_on = 1'b1;
    tick_en = 1'b1;

    // vector table
    for (int k = 0; k < 8; k++) begin
      mode_pdm = VECS[k][16];
      write_cmp(VECS[k][15:8]);
      wait_wrap();
      count_period(h, p);
      if (VECS[k][15:8] == 8'd0 || VECS[k][15:8] == 8'd255)
        check("R9", h, VECS[k][7:0]);
      else if (VECS[k][16])
        check("R4", h, VECS[k][7:0]);
      else
        check("R3", h, VECS[k][7:0]);
      if (VECS[k][16] && VECS[k][15:8] <= 8'd128) check("R4", p, 0);
    end

    // R2: 256 enabled ticks between interrupts
    while (!ovf_irq_o) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!ovf_irq_o);
    check("R2", n, 256);
    // R2: hold while disabled
    tick_en = 1'b0;
    n = 0;
    repeat (40) begin @(negedge clk); if (ovf_irq_o) n++; end
    check("R2", n, 0);
    tick_en = 1'b1;

    // R5: mid-period write leaves current period alone
    mode_pdm = 1'b0;
    write_cmp(8'd0);
    wait_wrap();
    wait_cnt(8'd10);
    write_cmp(8'd255);
    h = 0;
    while (m_cnt != 8'd0) begin if (wave_o) h++; @(negedge clk); end
    check("R5", h, 0);
    count_period(h, p);
    check("R5", h, 255);

    // R6: last write wins
    write_cmp(8'd40);
    write_cmp(8'd77);
    wait_wrap();
    count_period(h, p);
    check("R6", h, 77);
    // R6: write on the wrap edge itself
    wait_cnt(8'd255);
    write_cmp(8'd9);
    check("R6", m_cnt, 0);
    count_period(h, p);
    check("R6", h, 9);

    // R7: mode request mid-period waits for the wrap
    wait_cnt(8'd100);
    mode_pdm = 1'b1;
    h = 0;
    while (m_cnt != 8'd0) begin if (wave_o) h++; @(negedge clk); end
    check("R7", h, 0);
    count_period(h, p);
    check("R7", h, 9);
    check("R7", p, 0);

    // R8: masking
    irq_mask = 1'b1;
    n = 0;
    repeat (300) begin @(negedge clk); if (ovf_irq_o) n++; end
    check("R8", n, 0);
    irq_mask = 1'b0;
    n = 0;
    repeat (256) begin @(negedge clk); if (ovf_irq_o) n++; end
    check("R8", n, 1);

    done = 1'b1;
    mon_on = 1'b0;
    finish_run();
  end
endmodule